// File: doc/BRIEF.md
# Media Decode Command Front End

This block is the register-side entry point of a media decode unit. Software writes 32-bit words to a command register and a control register inside a 256-byte offset window. A command write is decoded by its top four bits. Two opcodes complete in the same cycle: buffer clear and threshold set. The other defined opcodes go busy, start an external sub-unit through a one-cycle start pulse, and wait for its done strobe. The block keeps a bit pointer into the input stream and the busy, end-of-data and start-code flags. It captures sub-unit results and raises a one-cycle interrupt pulse when an event calls for one.

The control path is a three-state machine. ST_IDLE goes to ST_ISSUE on the transition "accept long opcode". ST_ISSUE goes to ST_WAIT on "start sent", which is unconditional after one cycle. ST_WAIT goes to ST_IDLE on "sub-unit done". Any state goes to ST_IDLE on "soft reset". The control register holds an 8-bit decode configuration. Bit 30 of a control write acts as a soft reset of all command state.

Top module: `mdu_cmd_front`

## Requirements
- R1: Register offsets are: command 0x00, control 0x10, bit pointer 0x20, top-of-stream 0x30. Any other offset reads 0. Reads are combinational. A command read returns {busy, result[30:0]}. A control read returns busy in bit 31, start-code in bit 17, end-of-data in bit 16, the coded-block pattern in bits 13:8 and the configuration in bits 7:0. A pointer read returns the 7-bit pointer in bits 6:0. A top read returns {busy, top[30:0]}.
- R2: The opcode sits in bits 31:28. Opcode 0 (buffer clear) loads the bit pointer from bits 6:0. In the cycle after the write it pulses `fifo_clear` and `irq` for one cycle, and it never sets busy.
- R3: Opcode 6 (set threshold) loads `thresh` with {bits 23:16, bits 7:0}. It pulses `irq` in the cycle after the write and never sets busy.
- R4: Opcodes 3 (VLC decode), 4 (fixed decode) and 5 (set quant matrix) add bits 5:0 to the bit pointer, modulo 128. No other opcode changes the pointer except opcode 0.
- R5: Opcodes 1, 2, 3, 4, 5, 7, 8 and 9 are long. In the cycle after the write, `sub_start` is high for exactly one cycle and `sub_op`/`sub_arg` hold the opcode and the word. Bit 31 of the command, control and top reads stays 1 from that cycle until the cycle after `sub_done` is seen in the waiting state.
- R6: During VLC decode, `vlc_table` equals command bits 27:26 (0 address increment, 1 macroblock type, 2 motion code, 3 dual-prime vector). On completion the command result takes `sub_result`, and end-of-data is set exactly when that result is zero.
- R7: On fixed-decode completion, `sub_result` is loaded into both the command result and the top-of-stream register.
- R8: Every accepted command write clears the end-of-data and start-code flags.
- R9: On block-decode (opcode 2) completion, the block copies `sub_scd`, `sub_ecd` and `sub_cbp` into the status. It pulses `irq` in the next cycle exactly when `sub_scd` or `sub_ecd` is set.
- R10: A control write stores bits 7:0 as the configuration. A value of 3 in configuration bits 1:0 is stored as 1.
- R11: A control write with bit 30 set clears busy, the bit pointer, the top register, the command result, the coded-block pattern and both flags. It pulses `fifo_clear` in the next cycle. The configuration still takes the written bits.
- R12: A command write while busy has no effect. A `sub_done` pulse while not waiting has no effect.
- R13: Opcodes 10 to 15 only clear the flags. They leave busy, pointer and irq untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset in the window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset in the window |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt pulse |
| fifo_clear | output | 1 | Input FIFO flush pulse |
| bit_ptr | output | 7 | Stream bit pointer |
| dec_cfg | output | 8 | Decode configuration |
| thresh | output | 16 | Colour threshold pair |
| sub_start | output | 1 | Sub-unit start pulse |
| sub_op | output | 4 | Opcode of the running command |
| sub_arg | output | 32 | Word of the running command |
| vlc_table | output | 2 | VLC table select |
| sub_done | input | 1 | Sub-unit completion strobe |
| sub_result | input | 31 | Sub-unit result |
| sub_scd | input | 1 | Start code seen by block decode |
| sub_ecd | input | 1 | End of data seen by block decode |
| sub_cbp | input | 6 | Coded-block pattern from block decode |

## Verification
The bench drives directed sequences for each opcode class:
- immediate opcodes, which separate the pointer load from the pointer skip;
- long opcodes with zero and non-zero results, which separate setting end-of-data from leaving it clear;
- block decode with and without flags, which separates the interrupt and no-interrupt outcomes;
- writes during busy and stray done strobes, which show that nothing changes;
- a soft reset in mid-command.

A seeded random run then mixes clear, skip, threshold and long opcodes with random fields and results. A reference model predicts the pointer, thresholds, interrupt and results. This exposes wrap-around of the pointer and mix-ups between the skip and load fields.

// File: rtl/mdu_cmd_pkg.sv
package mdu_cmd_pkg;

    localparam logic [3:0] OP_CLEAR = 4'd0;
    localparam logic [3:0] OP_IDEC  = 4'd1;
    localparam logic [3:0] OP_BDEC  = 4'd2;
    localparam logic [3:0] OP_VDEC  = 4'd3;
    localparam logic [3:0] OP_FDEC  = 4'd4;
    localparam logic [3:0] OP_SETIQ = 4'd5;
    localparam logic [3:0] OP_SETTH = 4'd6;
    localparam logic [3:0] OP_CSC   = 4'd7;
    localparam logic [3:0] OP_PACK  = 4'd8;
    localparam logic [3:0] OP_SETVQ = 4'd9;

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_PTR  = 8'h20;
    localparam logic [7:0] OFS_TOP  = 8'h30;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fsm_state_e;

    function automatic logic op_is_long(input logic [3:0] op);
        return (op != OP_CLEAR) && (op != OP_SETTH) && (op <= OP_SETVQ);
    endfunction

    function automatic logic op_has_skip(input logic [3:0] op);
        return (op == OP_VDEC) || (op == OP_FDEC) || (op == OP_SETIQ);
    endfunction

endpackage

// File: rtl/mdu_ctrl_reg.sv
module mdu_ctrl_reg #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic             wr_rst,
    output logic [CFG_W-1:0] cfg,
    output logic             srst
);
    logic [CFG_W-1:0] fixed;

    assign srst = wr && wr_rst;

    always_comb begin
        fixed = wr_cfg;
        if (wr_cfg[1:0] == 2'b11)
            fixed[1:0] = 2'b01;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr)
            cfg <= fixed;
    end

    AST_PREC_FIXUP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_cfg[1:0] == 2'b11) |=> (cfg[1:0] == 2'b01)); // R10

endmodule

// File: rtl/mdu_bitptr.sv
module mdu_bitptr #(
    parameter int BP_W   = 7,
    parameter int SKIP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              load,
    input  logic [BP_W-1:0]   load_val,
    input  logic              skip_en,
    input  logic [SKIP_W-1:0] skip,
    output logic [BP_W-1:0]   bp
);
    localparam int PAD = BP_W - SKIP_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bp <= '0;
        else if (srst)
            bp <= '0;
        else if (load)
            bp <= load_val;
        else if (skip_en)
            bp <= bp + {{PAD{1'b0}}, skip};
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !srst) |=> (bp == $past(load_val))); // R2

    AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (bp == '0)); // R11

endmodule

// File: rtl/mdu_cmd_fsm.sv
module mdu_cmd_fsm
    import mdu_cmd_pkg::*;
#(
    parameter int BP_W   = 7,
    parameter int SKIP_W = 6,
    parameter int RES_W  = 31,
    parameter int CBP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_word,
    input  logic              sub_done,
    input  logic [RES_W-1:0]  sub_result,
    input  logic              sub_scd,
    input  logic              sub_ecd,
    input  logic [CBP_W-1:0]  sub_cbp,
    output logic              busy,
    output logic              sub_start,
    output logic [31:0]       sub_arg,
    output logic [RES_W-1:0]  cmd_data,
    output logic [RES_W-1:0]  top_data,
    output logic              scd,
    output logic              ecd,
    output logic [CBP_W-1:0]  cbp,
    output logic              irq,
    output logic              fifo_clear,
    output logic [15:0]       thresh,
    output logic              bp_load,
    output logic [BP_W-1:0]   bp_load_val,
    output logic              skip_en,
    output logic [SKIP_W-1:0] skip
);
    fsm_state_e state, state_nx;
    logic [3:0] op;
    logic       accept;
    logic       finish;

    assign op          = cmd_word[31:28];
    assign accept      = cmd_wr && (state == ST_IDLE);
    assign finish      = (state == ST_WAIT) && sub_done;
    assign bp_load     = accept && (op == OP_CLEAR);
    assign bp_load_val = cmd_word[BP_W-1:0];
    assign skip_en     = accept && op_has_skip(op);
    assign skip        = cmd_word[SKIP_W-1:0];
    assign busy        = (state != ST_IDLE);
    assign sub_start   = (state == ST_ISSUE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && op_is_long(op)) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (sub_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
        if (srst)
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_arg    <= '0;
            cmd_data   <= '0;
            top_data   <= '0;
            scd        <= 1'b0;
            ecd        <= 1'b0;
            cbp        <= '0;
            irq        <= 1'b0;
            fifo_clear <= 1'b0;
            thresh     <= '0;
        end else if (srst) begin
            sub_arg    <= '0;
            cmd_data   <= '0;
            top_data   <= '0;
            scd        <= 1'b0;
            ecd        <= 1'b0;
            cbp        <= '0;
            irq        <= 1'b0;
            fifo_clear <= 1'b1;
        end else begin
            irq        <= 1'b0;
            fifo_clear <= 1'b0;
            if (accept) begin
                scd     <= 1'b0;
                ecd     <= 1'b0;
                sub_arg <= cmd_word;
                if (op == OP_CLEAR) begin
                    fifo_clear <= 1'b1;
                    irq        <= 1'b1;
                end else if (op == OP_SETTH) begin
                    thresh <= {cmd_word[23:16], cmd_word[7:0]};
                    irq    <= 1'b1;
                end
            end
            if (finish) begin
                unique case (sub_arg[31:28])
                    OP_VDEC: begin
                        cmd_data <= sub_result;
                        ecd      <= (sub_result == '0);
                    end
                    OP_FDEC: begin
                        cmd_data <= sub_result;
                        top_data <= sub_result;
                    end
                    OP_BDEC: begin
                        scd <= sub_scd;
                        ecd <= sub_ecd;
                        cbp <= sub_cbp;
                        irq <= sub_scd || sub_ecd;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_start |=> !sub_start); // R5

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sub_done && !srst) |=> busy); // R5

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && fifo_clear)); // R11

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !srst) |=> $stable(sub_arg)); // R12

    AST_BDEC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !srst && sub_arg[31:28] == OP_BDEC && (sub_scd || sub_ecd)) |=> irq); // R9

endmodule

// File: rtl/mdu_cmd_front.sv
module mdu_cmd_front
    import mdu_cmd_pkg::*;
#(
    parameter int BP_W   = 7,
    parameter int SKIP_W = 6,
    parameter int RES_W  = 31,
    parameter int CBP_W  = 6,
    parameter int CFG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       rd_addr,
    output logic [31:0]      rd_data,
    output logic             irq,
    output logic             fifo_clear,
    output logic [BP_W-1:0]  bit_ptr,
    output logic [CFG_W-1:0] dec_cfg,
    output logic [15:0]      thresh,
    output logic             sub_start,
    output logic [3:0]       sub_op,
    output logic [31:0]      sub_arg,
    output logic [1:0]       vlc_table,
    input  logic             sub_done,
    input  logic [RES_W-1:0] sub_result,
    input  logic             sub_scd,
    input  logic             sub_ecd,
    input  logic [CBP_W-1:0] sub_cbp
);
    logic              srst, busy, scd, ecd;
    logic              bp_load, skip_en;
    logic [BP_W-1:0]   bp_load_val;
    logic [SKIP_W-1:0] skip;
    logic [RES_W-1:0]  cmd_data, top_data;
    logic [CBP_W-1:0]  cbp;
    logic              cmd_hit, ctrl_hit;

    assign cmd_hit   = wr_en && (wr_addr == OFS_CMD);
    assign ctrl_hit  = wr_en && (wr_addr == OFS_CTRL);
    assign sub_op    = sub_arg[31:28];
    assign vlc_table = sub_arg[27:26];

    mdu_ctrl_reg #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_hit),
        .wr_cfg(wr_data[CFG_W-1:0]), .wr_rst(wr_data[30]),
        .cfg(dec_cfg), .srst(srst)
    );

    mdu_bitptr #(.BP_W(BP_W), .SKIP_W(SKIP_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .load(bp_load), .load_val(bp_load_val),
        .skip_en(skip_en), .skip(skip), .bp(bit_ptr)
    );

    mdu_cmd_fsm #(.BP_W(BP_W), .SKIP_W(SKIP_W), .RES_W(RES_W), .CBP_W(CBP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .cmd_wr(cmd_hit), .cmd_word(wr_data),
        .sub_done(sub_done), .sub_result(sub_result),
        .sub_scd(sub_scd), .sub_ecd(sub_ecd), .sub_cbp(sub_cbp),
        .busy(busy), .sub_start(sub_start), .sub_arg(sub_arg),
        .cmd_data(cmd_data), .top_data(top_data),
        .scd(scd), .ecd(ecd), .cbp(cbp),
        .irq(irq), .fifo_clear(fifo_clear), .thresh(thresh),
        .bp_load(bp_load), .bp_load_val(bp_load_val),
        .skip_en(skip_en), .skip(skip)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_CMD:  rd_data = {busy, cmd_data};
            OFS_CTRL: begin
                rd_data[31]             = busy;
                rd_data[17]             = scd;
                rd_data[16]             = ecd;
                rd_data[8 +: CBP_W]     = cbp;
                rd_data[CFG_W-1:0]      = dec_cfg;
            end
            OFS_PTR:  rd_data[BP_W-1:0] = bit_ptr;
            OFS_TOP:  rd_data = {busy, top_data};
            default:  rd_data = '0;
        endcase
    end

    AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_start |-> (rd_addr != OFS_CMD || rd_data[31])); // R5

endmodule

// File: tb/tb_mdu_cmd_front.sv
module tb_mdu_cmd_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, fifo_clear, sub_start;
    logic [6:0]  bit_ptr;
    logic [7:0]  dec_cfg;
    logic [15:0] thresh;
    logic [3:0]  sub_op;
    logic [31:0] sub_arg;
    logic [1:0]  vlc_table;
    logic        sub_done = 1'b0;
    logic [30:0] sub_result = '0;
    logic        sub_scd = 1'b0, sub_ecd = 1'b0;
    logic [5:0]  sub_cbp = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdu_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .fifo_clear(fifo_clear),
        .bit_ptr(bit_ptr), .dec_cfg(dec_cfg), .thresh(thresh), .sub_start(sub_start),
        .sub_op(sub_op), .sub_arg(sub_arg), .vlc_table(vlc_table), .sub_done(sub_done),
        .sub_result(sub_result), .sub_scd(sub_scd), .sub_ecd(sub_ecd), .sub_cbp(sub_cbp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_sub(input logic [30:0] r, input logic s, input logic e, input logic [5:0] c);
        @(negedge clk);
        sub_done = 1'b1; sub_result = r; sub_scd = s; sub_ecd = e; sub_cbp = c;
        @(negedge clk);
        sub_done = 1'b0;
    endtask

    function automatic logic [6:0] model_bp(input logic [6:0] bp, input logic [31:0] w);
        logic [3:0] op = w[31:28];
        if (op == 4'd0) return w[6:0];
        if (op == 4'd3 || op == 4'd4 || op == 4'd5) return bp + {1'b0, w[5:0]};
        return bp;
    endfunction

    function automatic logic model_long(input logic [3:0] op);
        return op != 4'd0 && op != 4'd6 && op <= 4'd9;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [6:0]  ebp;
        logic [15:0] eth;
        logic [31:0] w;
        logic [30:0] r;
        int seed;
        seed = 7;
        v = $urandom(seed);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h10, v); chk("R1 ctrl reset", v, 32'h0);
        rd(8'h20, v); chk("R1 ptr reset", v, 32'h0);
        rd(8'h44, v); chk("R1 unmapped", v, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2 buffer clear
        wr(8'h00, 32'h0000_0055);
        chk("R2 irq", {31'b0, irq}, 32'h1);
        chk("R2 fifo_clear", {31'b0, fifo_clear}, 32'h1);
        rd(8'h20, v); chk("R2 ptr", v, 32'h55);
        rd(8'h00, v); chk("R2 not busy", {31'b0, v[31]}, 32'h0);
        @(negedge clk);
        chk("R2 irq one cycle", {31'b0, irq}, 32'h0);

        // R4 R5 R6 VLC decode with skip
        wr(8'h00, 32'h3800_002F);
        rd(8'h20, v); chk("R4 skip", v, 32'h04);
        chk("R5 start", {31'b0, sub_start}, 32'h1);
        chk("R5 sub_op", {28'b0, sub_op}, 32'h3);
        chk("R6 table", {30'b0, vlc_table}, 32'h2);
        rd(8'h10, v); chk("R5 ctrl busy", {31'b0, v[31]}, 32'h1);
        rd(8'h30, v); chk("R5 top busy", {31'b0, v[31]}, 32'h1);
        @(negedge clk);
        chk("R5 start one cycle", {31'b0, sub_start}, 32'h0);
        rd(8'h00, v); chk("R5 still busy", {31'b0, v[31]}, 32'h1);
        finish_sub(31'h0005_0003, 1'b0, 1'b0, 6'h0);
        rd(8'h00, v); chk("R6 result", v, 32'h0005_0003);
        rd(8'h10, v); chk("R6 ecd clear", {31'b0, v[16]}, 32'h0);

        // R6 zero result sets end-of-data
        wr(8'h00, 32'h3000_0000);
        finish_sub(31'h0, 1'b0, 1'b0, 6'h0);
        rd(8'h10, v); chk("R6 ecd set", {31'b0, v[16]}, 32'h1);

        // R3 R8 threshold clears flags
        wr(8'h00, 32'h6033_0044);
        chk("R3 irq", {31'b0, irq}, 32'h1);
        chk("R3 thresh", {16'b0, thresh}, 32'h3344);
        rd(8'h10, v); chk("R8 ecd cleared", {31'b0, v[16]}, 32'h0);
        chk("R3 not busy", {31'b0, v[31]}, 32'h0);

        // R7 fixed decode
        wr(8'h00, 32'h4000_0001);
        rd(8'h20, v); chk("R4 fdec skip", v, 32'h05);
        finish_sub(31'h1234_5678, 1'b0, 1'b0, 6'h0);
        rd(8'h00, v); chk("R7 cmd", v, 32'h1234_5678);
        rd(8'h30, v); chk("R7 top", v, 32'h1234_5678);

        // R9 block decode with start code
        wr(8'h00, 32'h2000_003F);
        rd(8'h20, v); chk("R4 bdec no skip", v, 32'h05);
        finish_sub(31'h0, 1'b1, 1'b0, 6'h2A);
        chk("R9 irq", {31'b0, irq}, 32'h1);
        rd(8'h10, v);
        chk("R9 scd", {31'b0, v[17]}, 32'h1);
        chk("R9 cbp", {26'b0, v[13:8]}, 32'h2A);
        wr(8'h00, 32'h2000_0000);
        finish_sub(31'h0, 1'b0, 1'b0, 6'h11);
        chk("R9 no irq", {31'b0, irq}, 32'h0);

        // R12 write while busy, stray done
        wr(8'h00, 32'h1000_0000);
        wr(8'h00, 32'h0000_0011);
        chk("R12 no irq", {31'b0, irq}, 32'h0);
        rd(8'h20, v); chk("R12 ptr kept", v, 32'h05);
        chk("R12 op kept", {28'b0, sub_op}, 32'h1);
        finish_sub(31'h7, 1'b0, 1'b0, 6'h0);
        rd(8'h00, v); chk("R12 idle", {31'b0, v[31]}, 32'h0);
        finish_sub(31'h7FFF, 1'b1, 1'b1, 6'h3F);
        rd(8'h00, v); chk("R12 stray done", v, 32'h1234_5678);
        chk("R12 stray irq", {31'b0, irq}, 32'h0);

        // R10 precision fixup
        wr(8'h10, 32'h0000_00A7);
        rd(8'h10, v); chk("R10 fixup", {24'b0, v[7:0]}, 32'hA5);
        wr(8'h10, 32'h0000_0002);
        rd(8'h10, v); chk("R10 plain", {24'b0, v[7:0]}, 32'h02);

        // R13 reserved opcode
        wr(8'h00, 32'h3000_0000);
        finish_sub(31'h0, 1'b0, 1'b0, 6'h0);
        wr(8'h00, 32'hB000_0003);
        chk("R13 no irq", {31'b0, irq}, 32'h0);
        rd(8'h10, v);
        chk("R13 ecd cleared", {31'b0, v[16]}, 32'h0);
        chk("R13 not busy", {31'b0, v[31]}, 32'h0);
        rd(8'h20, v); chk("R13 ptr", v, 32'h05);

        // R11 soft reset in mid-command
        wr(8'h00, 32'h7000_0000);
        wr(8'h10, 32'h4000_0005);
        chk("R11 fifo_clear", {31'b0, fifo_clear}, 32'h1);
        rd(8'h00, v); chk("R11 cmd", v, 32'h0);
        rd(8'h30, v); chk("R11 top", v, 32'h0);
        rd(8'h20, v); chk("R11 ptr", v, 32'h0);
        rd(8'h10, v); chk("R11 ctrl", v, 32'h05);

        // random mix
        ebp = 7'h0;
        eth = thresh;
        for (int i = 0; i < 300; i++) begin
            logic [3:0] op;
            int pick;
            pick = $urandom_range(0, 5);
            op = (pick == 0) ? 4'd0 : (pick == 1) ? 4'd3 : (pick == 2) ? 4'd4 :
                 (pick == 3) ? 4'd5 : (pick == 4) ? 4'd6 : 4'd1;
            w = {op, 28'($urandom)};
            wr(8'h00, w);
            ebp = model_bp(ebp, w);
            if (op == 4'd6) eth = {w[23:16], w[7:0]};
            chk("R4 random ptr", {25'b0, bit_ptr}, {25'b0, ebp});
            chk("R3 random thresh", {16'b0, thresh}, {16'b0, eth});
            chk("R2 random irq", {31'b0, irq}, {31'b0, (op == 4'd0 || op == 4'd6)});
            chk("R5 random start", {31'b0, sub_start}, {31'b0, model_long(op)});
            if (model_long(op)) begin
                r = 31'($urandom);
                if ($urandom_range(0, 7) == 0) r = '0;
                finish_sub(r, 1'b0, 1'b0, 6'h0);
                if (op == 4'd3 || op == 4'd4) begin
                    rd(8'h00, v); chk("R6 random result", v, {1'b0, r});
                end
                if (op == 4'd3) begin
                    rd(8'h10, v); chk("R6 random ecd", {31'b0, v[16]}, {31'b0, r == '0});
                end
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule